// File: doc/BRIEF.md
# Interrupt Acceptance Sequencer

This block sits beside a small 8-bit processor core and decides when an interrupt is taken and what happens while it is taken. Every source has its own request latch that catches a one-cycle request pulse and keeps it until the source is serviced or software overwrites it. The low-numbered sources are non-maskable. Every other source is gated by its own enable flag and by one master enable flag. Among the eligible pending sources, the lowest index wins.

When the core signals that an instruction has finished and an eligible source is pending, the block starts a fixed eight-cycle acceptance sequence. It clears the master flag and the winner's latch. It writes the status byte, with the old master flag merged in, and then both program-counter bytes, onto a stack that grows downward. It reads the winner's vector slot. In the last cycle it loads the new program counter and the lowered stack pointer into the core. A return strobe from the core restores the master flag from the popped status byte.

The stack write port, the vector read and the PC/SP load outputs cannot be stalled. The sequence has a fixed length, so the stack memory must accept a write on every cycle in which `stk_we` is high. The vector memory must answer one cycle after `vec_rd`. The core must hold off instruction issue while `acc_busy` is high.

Top module: `irq_accept_ctrl`

## Requirements
- R1: A set request latch stays set until its source is accepted or until a register write replaces its latch byte. A pending source with no `instr_done` strobe is never accepted. A written 0 clears the latch.
- R2: Acceptance starts on the cycle after an `instr_done` strobe that sees an eligible pending source while the block is idle. `acc_busy` is then high for exactly 8 cycles.
- R3: On acceptance the master flag becomes 0 and the winner's latch is cleared. Afterwards no maskable source is accepted until the master flag is set again.
- R4: The three stack writes come in consecutive cycles in this order. First the status byte `{cpu_flags, master}` (master in bit 0) goes to address SP. Next PC[15:8] goes to SP-1. Last PC[7:0] goes to SP-2.
- R5: `vec_rd` is raised for one cycle with `vec_addr` equal to the winner's index, and `vec_data` is taken one cycle later. In the final sequence cycle, `pc_load` and `sp_load` pulse together, with `pc_out` equal to the vector entry and `sp_out` equal to SP-3.
- R6: Register map, with `reg_addr` k in 0 to 2 holding the enable flags of sources 8k to 8k+7 at bit (index mod 8). Address 0 bit 0 is the master flag. Address 0 bits 3..1 have no effect. Addresses 4 to 6 hold the latches of the same sources at the same bit positions, and a write replaces that latch byte.
- R7: Sources 0 to 3 are non-maskable and are accepted regardless of the master and enable flags. Any other source needs both its enable flag and the master flag set.
- R8: Among eligible pending sources the lowest index is accepted.
- R9: A `ret_mask` or `ret_nmi` strobe loads the master flag from `ret_master`.
- R10: After reset, all latches, enable flags and the master flag are 0, and `acc_busy`, `stk_we`, `vec_rd`, `pc_load` and `sp_load` are low.
- R11: When a latch-byte write and a request for the same source share a cycle, the latch ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req | input | NUM_SRC | One-cycle request pulses, one per source |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register write address |
| reg_wdata | input | 8 | Register write data |
| instr_done | input | 1 | Current instruction has completed |
| ret_mask | input | 1 | Return from a maskable service routine |
| ret_nmi | input | 1 | Return from a non-maskable service routine |
| ret_master | input | 1 | Master bit of the status byte popped on return |
| cpu_pc | input | 16 | Program counter to save |
| cpu_flags | input | 7 | Status bits saved above the master bit |
| cpu_sp | input | AW | Current stack pointer |
| acc_busy | output | 1 | Acceptance sequence in progress |
| stk_we | output | 1 | Stack write enable |
| stk_addr | output | AW | Stack write address |
| stk_wdata | output | 8 | Stack write data |
| vec_rd | output | 1 | Vector table read strobe |
| vec_addr | output | $clog2(NUM_SRC) | Vector slot index |
| vec_data | input | 16 | Vector entry, valid one cycle after vec_rd |
| pc_load | output | 1 | Load pc_out into the program counter |
| pc_out | output | 16 | Service routine entry address |
| sp_load | output | 1 | Load sp_out into the stack pointer |
| sp_out | output | AW | Stack pointer after the three pushes |

## Verification
The bound checker watches, on every cycle, several properties of the acceptance sequence. It checks that the busy window lasts eight cycles and begins only after an instruction-complete strobe, that the master flag is down when a sequence begins, and that consecutive stack writes step down by one address. It also checks that pending latches never drop without a write or an acceptance, that the PC and SP loads coincide inside the window, and that return strobes restore the master flag. The contents of each pushed byte, the vector entry that lands in the PC, the priority among competing sources, the register bit layout and the outcome of a write racing a request depend on the stimulus, so only the directed scenarios of the bench show them.

// File: rtl/irq_acc_pkg.sv
`timescale 1ns/1ps
package irq_acc_pkg;
  // Fixed steps of the acceptance sequence; the length is part of the behaviour.
  typedef enum logic [2:0] {
    STP_PSW  = 3'd0,
    STP_PCH  = 3'd1,
    STP_PCL  = 3'd2,
    STP_VRD  = 3'd3,
    STP_VCAP = 3'd4,
    STP_PAD0 = 3'd5,
    STP_PAD1 = 3'd6,
    STP_LOAD = 3'd7
  } acc_step_e;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned LAT_BASE = 4;   // first latch-byte address
endpackage

// File: rtl/irq_src_regs.sv
`timescale 1ns/1ps
module irq_src_regs
  import irq_acc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 22,
  parameter int unsigned NUM_NMI = 4,
  parameter int unsigned REG_AW  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_SRC-1:0]  src_req,
  input  logic                reg_we,
  input  logic [REG_AW-1:0]   reg_addr,
  input  logic [BYTE_W-1:0]   reg_wdata,
  input  logic [NUM_SRC-1:0]  clr_vec,
  input  logic                accept,
  input  logic                ret_any,
  input  logic                ret_master,
  output logic [NUM_SRC-1:0]  latch_o,
  output logic [NUM_SRC-1:0]  elig_o,
  output logic                master_o
);
  logic master_q;
  logic wr_master;

  assign wr_master = reg_we && (reg_addr == REG_AW'(0));

  // Acceptance clears the master flag ahead of any return or register write.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          master_q <= 1'b0;
    else if (accept)     master_q <= 1'b0;
    else if (ret_any)    master_q <= ret_master;
    else if (wr_master)  master_q <= reg_wdata[0];
  end
  assign master_o = master_q;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    localparam int unsigned LANE = i / BYTE_W;
    localparam int unsigned BPOS = i % BYTE_W;
    logic lat_q;
    logic wr_lat;

    assign wr_lat = reg_we && (reg_addr == REG_AW'(LAT_BASE + LANE));

    // A request in the same cycle overrides both a write and the accept clear.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lat_q <= 1'b0;
      else        lat_q <= ((wr_lat ? reg_wdata[BPOS] : lat_q) & ~clr_vec[i]) | src_req[i];
    end
    assign latch_o[i] = lat_q;

    if (i < NUM_NMI) begin : g_nmi
      assign elig_o[i] = lat_q;
    end else begin : g_msk
      logic en_q;
      logic wr_en;
      assign wr_en = reg_we && (reg_addr == REG_AW'(LANE));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     en_q <= 1'b0;
        else if (wr_en) en_q <= reg_wdata[BPOS];
      end
      assign elig_o[i] = lat_q & en_q & master_q;
    end
  end
endmodule

// File: rtl/irq_prio.sv
`timescale 1ns/1ps
module irq_prio #(
  parameter int unsigned N   = 22,
  parameter int unsigned IDW = 5
) (
  input  logic [N-1:0]   req,
  output logic           any,
  output logic [IDW-1:0] id
);
  // Scan from the top so the lowest set index is the last one assigned.
  always_comb begin
    id = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) id = IDW'(i);
    end
  end
  assign any = |req;
endmodule

// File: rtl/irq_acc_seq.sv
`timescale 1ns/1ps
module irq_acc_seq
  import irq_acc_pkg::*;
#(
  parameter int unsigned AW  = 16,
  parameter int unsigned IDW = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IDW-1:0]    win_id,
  input  logic [15:0]       cur_pc,
  input  logic [6:0]        cur_flags,
  input  logic              cur_master,
  input  logic [AW-1:0]     cur_sp,
  input  logic [15:0]       vec_data,
  output logic              busy,
  output logic              stk_we,
  output logic [AW-1:0]     stk_addr,
  output logic [BYTE_W-1:0] stk_wdata,
  output logic              vec_rd,
  output logic [IDW-1:0]    vec_addr,
  output logic              pc_load,
  output logic [15:0]       pc_out,
  output logic              sp_load,
  output logic [AW-1:0]     sp_out
);
  acc_step_e         step_q;
  logic              busy_q;
  logic [IDW-1:0]    id_q;
  logic [15:0]       pc_q;
  logic [BYTE_W-1:0] psw_q;
  logic [AW-1:0]     sp_q;
  logic [15:0]       vec_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= STP_PSW;
      id_q   <= '0;
      pc_q   <= '0;
      psw_q  <= '0;
      sp_q   <= '0;
      vec_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      step_q <= STP_PSW;
      id_q   <= win_id;
      pc_q   <= cur_pc;
      psw_q  <= {cur_flags, cur_master};
      sp_q   <= cur_sp;
    end else if (busy_q) begin
      if (step_q == STP_VCAP) vec_q <= vec_data;
      if (step_q == STP_LOAD) begin
        busy_q <= 1'b0;
        step_q <= STP_PSW;
      end else begin
        step_q <= acc_step_e'(step_q + 3'd1);
      end
    end
  end

  always_comb begin
    stk_we    = 1'b0;
    stk_addr  = sp_q;
    stk_wdata = psw_q;
    vec_rd    = 1'b0;
    pc_load   = 1'b0;
    sp_load   = 1'b0;
    if (busy_q) begin
      unique case (step_q)
        STP_PSW: begin
          stk_we    = 1'b1;
        end
        STP_PCH: begin
          stk_we    = 1'b1;
          stk_addr  = sp_q - AW'(1);
          stk_wdata = pc_q[15:8];
        end
        STP_PCL: begin
          stk_we    = 1'b1;
          stk_addr  = sp_q - AW'(2);
          stk_wdata = pc_q[7:0];
        end
        STP_VRD:  vec_rd = 1'b1;
        STP_LOAD: begin
          pc_load = 1'b1;
          sp_load = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign busy     = busy_q;
  assign vec_addr = id_q;
  assign pc_out   = vec_q;
  assign sp_out   = sp_q - AW'(3);
endmodule

// File: rtl/irq_accept_ctrl.sv
`timescale 1ns/1ps
module irq_accept_ctrl
  import irq_acc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 22,
  parameter int unsigned NUM_NMI = 4,
  parameter int unsigned AW      = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         src_req,
  input  logic                       reg_we,
  input  logic [2:0]                 reg_addr,
  input  logic [7:0]                 reg_wdata,
  input  logic                       instr_done,
  input  logic                       ret_mask,
  input  logic                       ret_nmi,
  input  logic                       ret_master,
  input  logic [15:0]                cpu_pc,
  input  logic [6:0]                 cpu_flags,
  input  logic [AW-1:0]              cpu_sp,
  output logic                       acc_busy,
  output logic                       stk_we,
  output logic [AW-1:0]              stk_addr,
  output logic [7:0]                 stk_wdata,
  output logic                       vec_rd,
  output logic [$clog2(NUM_SRC)-1:0] vec_addr,
  input  logic [15:0]                vec_data,
  output logic                       pc_load,
  output logic [15:0]                pc_out,
  output logic                       sp_load,
  output logic [AW-1:0]              sp_out
);
  localparam int unsigned IDW = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] latch;
  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] clr_vec;
  logic               master;
  logic               win_any;
  logic [IDW-1:0]     win_id;
  logic               accept;

  assign accept  = instr_done && !acc_busy && win_any;
  assign clr_vec = accept ? (NUM_SRC'(1) << win_id) : '0;

  irq_src_regs #(.NUM_SRC(NUM_SRC), .NUM_NMI(NUM_NMI), .REG_AW(3)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .src_req    (src_req),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .clr_vec    (clr_vec),
    .accept     (accept),
    .ret_any    (ret_mask | ret_nmi),
    .ret_master (ret_master),
    .latch_o    (latch),
    .elig_o     (elig),
    .master_o   (master)
  );

  irq_prio #(.N(NUM_SRC), .IDW(IDW)) u_prio (
    .req (elig),
    .any (win_any),
    .id  (win_id)
  );

  irq_acc_seq #(.AW(AW), .IDW(IDW)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .win_id     (win_id),
    .cur_pc     (cpu_pc),
    .cur_flags  (cpu_flags),
    .cur_master (master),
    .cur_sp     (cpu_sp),
    .vec_data   (vec_data),
    .busy       (acc_busy),
    .stk_we     (stk_we),
    .stk_addr   (stk_addr),
    .stk_wdata  (stk_wdata),
    .vec_rd     (vec_rd),
    .vec_addr   (vec_addr),
    .pc_load    (pc_load),
    .pc_out     (pc_out),
    .sp_load    (sp_load),
    .sp_out     (sp_out)
  );
endmodule

// File: rtl/irq_accept_chk.sv
`timescale 1ns/1ps
module irq_accept_chk #(
  parameter int unsigned NUM_SRC = 22,
  parameter int unsigned AW      = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               instr_done,
  input logic               reg_we,
  input logic               ret_mask,
  input logic               ret_nmi,
  input logic               ret_master,
  input logic               acc_busy,
  input logic               stk_we,
  input logic [AW-1:0]      stk_addr,
  input logic               pc_load,
  input logic               sp_load,
  input logic               accept,
  input logic               master,
  input logic [NUM_SRC-1:0] latch
);
  logic [3:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= '0;
    else        busy_cnt <= acc_busy ? busy_cnt + 4'd1 : 4'd0;
  end

  p_seq_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_busy |-> (busy_cnt < 4'd8));

  p_seq_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(acc_busy) |-> ($past(busy_cnt) == 4'd7));

  p_start_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_busy) |-> $past(instr_done));

  p_master_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_busy) |-> !master);

  p_latch_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(reg_we) && !$past(accept)) |-> ((latch & $past(latch)) == $past(latch)));

  p_push_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_we && $past(stk_we)) |-> (stk_addr == $past(stk_addr) - AW'(1)));

  p_push_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stk_we |-> acc_busy);

  p_load_pair_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (sp_load && acc_busy));

  p_ret_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ret_mask || ret_nmi) && !$past(accept)) |-> (master == $past(ret_master)));
endmodule

bind irq_accept_ctrl irq_accept_chk #(.NUM_SRC(NUM_SRC), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .instr_done (instr_done),
  .reg_we     (reg_we),
  .ret_mask   (ret_mask),
  .ret_nmi    (ret_nmi),
  .ret_master (ret_master),
  .acc_busy   (acc_busy),
  .stk_we     (stk_we),
  .stk_addr   (stk_addr),
  .pc_load    (pc_load),
  .sp_load    (sp_load),
  .accept     (accept),
  .master     (master),
  .latch      (latch)
);

// File: tb/irq_accept_ctrl_test.sv
`timescale 1ns/1ps
module irq_accept_ctrl_test;
  localparam int NS = 22;
  localparam logic [15:0] PCV = 16'h1234;
  localparam logic [6:0]  FLG = 7'h2D;
  localparam logic [15:0] SPV = 16'h0180;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] src_req = '0;
  logic          reg_we = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [7:0]    reg_wdata = '0;
  logic          instr_done = 1'b0;
  logic          ret_mask = 1'b0;
  logic          ret_nmi = 1'b0;
  logic          ret_master = 1'b0;
  logic          acc_busy, stk_we, vec_rd, pc_load, sp_load;
  logic [15:0]   stk_addr, pc_out, sp_out;
  logic [7:0]    stk_wdata;
  logic [4:0]    vec_addr;
  logic [15:0]   vec_data;
  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  function automatic logic [15:0] vec_of(input int id);
    return 16'hC000 + 16'(id * 16);
  endfunction

  always_ff @(posedge clk) vec_data <= vec_of(int'(vec_addr));

  irq_accept_ctrl uut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .instr_done(instr_done),
    .ret_mask(ret_mask), .ret_nmi(ret_nmi), .ret_master(ret_master),
    .cpu_pc(PCV), .cpu_flags(FLG), .cpu_sp(SPV), .acc_busy(acc_busy),
    .stk_we(stk_we), .stk_addr(stk_addr), .stk_wdata(stk_wdata),
    .vec_rd(vec_rd), .vec_addr(vec_addr), .vec_data(vec_data),
    .pc_load(pc_load), .pc_out(pc_out), .sp_load(sp_load), .sp_out(sp_out)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse_req(input int s);
    @(negedge clk); src_req[s] = 1'b1;
    @(negedge clk); src_req = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic expect_idle(input string tag);
    bit seen = 1'b0;
    @(negedge clk); instr_done = 1'b1;
    @(negedge clk); instr_done = 1'b0;
    for (int i = 0; i < 10; i++) begin
      if (acc_busy) seen = 1'b1;
      @(negedge clk);
    end
    chk(!seen, tag, int'(seen), 0);
  endtask

  task automatic expect_accept(input int id, input bit m, input string tag);
    int nb = 0, np = 0, nv = 0, nl = 0;
    logic [15:0] a[3];
    logic [7:0]  d[3];
    logic [4:0]  va = '0;
    logic [15:0] pcv = '0, spv = '0;
    for (int k = 0; k < 3; k++) begin a[k] = '0; d[k] = '0; end
    @(negedge clk); instr_done = 1'b1;
    @(negedge clk); instr_done = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (acc_busy) nb++;
      if (stk_we) begin
        if (np < 3) begin a[np] = stk_addr; d[np] = stk_wdata; end
        np++;
      end
      if (vec_rd) begin nv++; va = vec_addr; end
      if (pc_load && sp_load) begin nl++; pcv = pc_out; spv = sp_out; end
      @(negedge clk);
    end
    chk(nb == 8 && !acc_busy, $sformatf("R2 busy length (%s)", tag), nb, 8);
    chk(np == 3, $sformatf("R4 push count (%s)", tag), np, 3);
    chk(d[0] == {FLG, m} && a[0] == SPV, $sformatf("R4 status push (%s)", tag), {a[0], d[0]}, {SPV, FLG, m});
    chk(d[1] == PCV[15:8] && a[1] == SPV - 1, $sformatf("R4 PC high push (%s)", tag), {a[1], d[1]}, {SPV - 16'd1, PCV[15:8]});
    chk(d[2] == PCV[7:0] && a[2] == SPV - 2, $sformatf("R4 PC low push (%s)", tag), {a[2], d[2]}, {SPV - 16'd2, PCV[7:0]});
    chk(nv == 1 && int'(va) == id, $sformatf("R5 vector slot (%s)", tag), int'(va), id);
    chk(nl == 1 && pcv == vec_of(id), $sformatf("R5 PC load (%s)", tag), pcv, vec_of(id));
    chk(spv == SPV - 3, $sformatf("R5 SP load (%s)", tag), spv, SPV - 16'd3);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!acc_busy && !stk_we && !vec_rd && !pc_load && !sp_load, "R10 idle outputs",
        {acc_busy, stk_we, vec_rd, pc_load, sp_load}, 0);
    expect_idle("R10 nothing pending after reset");
  endtask

  task automatic t_nmi;
    pulse_req(2);
    expect_accept(2, 1'b0, "R7 non-maskable with master off");
    expect_idle("R3 accepted latch cleared");
  endtask

  task automatic t_hold;
    bit seen = 1'b0;
    pulse_req(3);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (acc_busy) seen = 1'b1;
    end
    chk(!seen, "R1 no acceptance without instr_done", int'(seen), 0);
    expect_accept(3, 1'b0, "R1 latch held");
  endtask

  task automatic t_mask;
    wr(3'd0, 8'h1E);
    pulse_req(4);
    expect_idle("R6 bits 3..1 leave master off");
    wr(3'd0, 8'h11);
    expect_accept(4, 1'b1, "R7 maskable enabled");
    pulse_req(4);
    expect_idle("R3 master cleared by acceptance");
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h11);
    expect_idle("R1 latch cleared by write");
  endtask

  task automatic t_prio;
    wr(3'd0, 8'h21);
    wr(3'd1, 8'h02);
    pulse_req(9);
    pulse_req(5);
    expect_accept(5, 1'b1, "R8 lowest index wins");
    expect_idle("R3 second source waits for master");
    @(negedge clk); ret_mask = 1'b1; ret_master = 1'b1;
    @(negedge clk); ret_mask = 1'b0; ret_master = 1'b0;
    expect_accept(9, 1'b1, "R9 maskable return restores master");
  endtask

  task automatic t_nmi_ret;
    wr(3'd0, 8'h21);
    @(negedge clk); ret_nmi = 1'b1; ret_master = 1'b0;
    @(negedge clk); ret_nmi = 1'b0;
    pulse_req(9);
    expect_idle("R9 non-maskable return restores master 0");
    wr(3'd5, 8'h00);
    wr(3'd0, 8'h21);
    expect_idle("R6 latch byte 1 write clears source 9");
  endtask

  task automatic t_race;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'd4; reg_wdata = 8'h00; src_req[5] = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; src_req = '0;
    expect_accept(5, 1'b1, "R11 request beats latch write");
  endtask

  task automatic t_high;
    wr(3'd2, 8'h10);
    wr(3'd0, 8'h01);
    pulse_req(20);
    expect_accept(20, 1'b1, "R6 enable byte 2");
  endtask

  initial begin
    #800000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_nmi();
    t_hold();
    t_mask();
    t_prio();
    t_nmi_ret();
    t_race();
    t_high();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule